// File: doc/BRIEF.md
# Calendar Real-Time Clock with Masked Alarm

This block keeps wall-clock time for a chip. A prescaler divides the reference clock down to one tick per second. Each tick advances a calendar of eight fields: second, minute, hour, day of month, weekday, day of year, month and year. The calendar carries from one field to the next and follows month lengths and leap years. A signed calibration setting can insert an extra tick or drop a tick at a programmed interval, which trims long-term drift.

Software reaches the block through a simple 32-bit register port. Each field can be read and written through its own word. Three read-only words pack the whole time together for a single-read snapshot. An alarm compares every field with its own alarm register, and per-field mask bits leave chosen fields out of the comparison. Field-advance events and alarm hits are latched as pending bits that drive one interrupt line, and software clears them by writing.

Top module: `cal_rtc`

## Requirements
- R1: After reset the calendar reads second 0, minute 0, hour 0, day of month 1, weekday 0, day of year 1, month 1, year 0. The control word, pending word, flag word and calibration word read 0, the mask word reads 0xFF and `irq` is low.
- R2: The control word sits at 0x08, with bit 0 = run, bit 1 = prescaler hold and bit 4 = calibration off. When run is 1 and hold is 0, exactly one tick occurs every DIV_CYCLES clocks. When run is 0 or hold is 1, no tick occurs, and hold also returns the prescaler to phase zero.
- R3: On a tick, second and minute wrap from 59 to 0, hour wraps from 23 to 0, and weekday wraps from 6 to 0. Each wrap carries into the next field.
- R4: Day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for month 2 when year mod 4 is 0 (28 otherwise). Month wraps from 12 to 1 and increments the year. Day of year becomes 1 when the month wraps and otherwise increments on each new day.
- R5: The field words are at 0x20 + 4*i with i = 0 second, 1 minute, 2 hour, 3 day of month, 4 weekday, 5 day of year, 6 month, 7 year. A write stores the value cut to the field width (6, 6, 5, 5, 3, 12, 4, 12 bits) and reads back.
- R6: A field write in the same clock as a tick cancels that tick's advance and carry in every field, so the written value holds.
- R7: Snapshot word 0x14 holds second [5:0], minute [13:8], hour [20:16] and weekday [26:24]. Word 0x18 holds day of month [4:0], month [11:8] and year [27:16]. Word 0x1C holds day of year [11:0]. All other bits read 0.
- R8: The calibration word at 0x40 holds an interval N in bits 16:0 and a direction in bit 17. When calibration is on and N is nonzero, every N-th prescaler tick is followed one clock later by an extra tick (bit 17 = 0) or is dropped (bit 17 = 1). Control bit 4 disables this.
- R9: The alarm registers are at 0x60 + 4*i, in the field order of R5. The mask word at 0x10 uses bit i for field i, and a 1 excludes that field. When every unmasked field equals its alarm register after a tick, bit 1 of the flag word (0x00) is set.
- R10: A mask of 0xFF disables the alarm. The alarm flag is set only following a tick, so clearing it while the fields still match leaves it clear until a later matching tick.
- R11: The pending word at 0x0C gets bit i set whenever a tick changes field i. A write replaces its contents, so writing 0 clears it. Each tick also sets bit 0 of the flag word.
- R12: Writing 1 to a flag-word bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while the pending word is nonzero or the alarm flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt: pending events or alarm flag |

## Verification
The bench builds the block with DIV_CYCLES = 8. At that setting a second lasts eight clocks, so runs of one to six ticks starting near day, month and year boundaries finish within a few dozen cycles, and the tick edge can be hit on an exact clock to collide with a field write. It sets a calibration interval of 3 so that both the inserted and the dropped tick show up in a six-tick window. Random start dates bias toward 23:59:5x and month-end days over all years 0 to 4095, so leap and non-leap February and the December wrap are exercised repeatedly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFLD   = 8;
  localparam int FLD_W  = 12;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  typedef logic [NFLD-1:0][FLD_W-1:0] fields_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOM  = 3;
  localparam int F_DOW  = 4;
  localparam int F_DOY  = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  localparam logic [ADDR_W-1:0] A_FLAG = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] A_PEND = 8'h0C;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] A_PK0  = 8'h14;
  localparam logic [ADDR_W-1:0] A_PK1  = 8'h18;
  localparam logic [ADDR_W-1:0] A_PK2  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CAL  = 8'h40;
  localparam logic [2:0] REGION_FLD = 3'b001;
  localparam logic [2:0] REGION_ALM = 3'b011;

  function automatic logic [FLD_W-1:0] fld_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:  return 12'h03F;
      F_HOUR, F_DOM: return 12'h01F;
      F_DOW:         return 12'h007;
      F_MON:         return 12'h00F;
      default:       return 12'hFFF;
    endcase
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [FLD_W-1:0] yr);
    case (mon)
      4'd2:                    return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV   = 32768,
  parameter int CAL_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             cal_en,
  input  logic             cal_back,
  input  logic [CAL_W-1:0] cal_cnt,
  output logic             tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0]    div_q, div_d;
  logic [CAL_W-1:0] cal_q, cal_d;
  logic             extra_q, extra_d;
  logic             raw, cal_act, cal_hit, div_en, cal_upd;

  always_comb begin
    raw     = run && !hold && (div_q == LAST);
    cal_act = cal_en && (cal_cnt != '0);
    cal_hit = raw && cal_act && (cal_q >= (cal_cnt - 1'b1));
    div_en  = run || hold;
    div_d   = hold ? '0 : (raw ? '0 : div_q + 1'b1);
    cal_upd = hold || !cal_act || raw;
    if (hold || !cal_act) cal_d = '0;
    else                  cal_d = cal_hit ? '0 : cal_q + 1'b1;
    extra_d = cal_hit && !cal_back;
    tick    = (raw && !(cal_hit && cal_back)) || extra_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cal_q   <= '0;
      extra_q <= 1'b0;
    end else begin
      if (div_en)  div_q <= div_d;
      if (cal_upd) cal_q <= cal_d;
      extra_q <= extra_d;
    end
  end

  // R8: an inserted tick always follows a prescaler tick by one clock
  a_r8_extra_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !raw) |-> $past(raw));
  // R2: prescaler ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    raw |=> !raw);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [FLD_W-1:0] wr_val,
  output fields_t          fld,
  output logic [NFLD-1:0]  changed
);
  fields_t    nxt;
  logic       s_w, m_w, h_w, d_w, mo_w, upd;
  logic [4:0] dim;

  always_comb begin
    nxt  = fld;
    s_w  = fld[F_SEC]  >= 12'd59;
    m_w  = fld[F_MIN]  >= 12'd59;
    h_w  = fld[F_HOUR] >= 12'd23;
    dim  = month_days(fld[F_MON][3:0], fld[F_YEAR]);
    d_w  = fld[F_DOM]  >= {7'd0, dim};
    mo_w = fld[F_MON]  >= 12'd12;
    if (adv) begin
      nxt[F_SEC] = s_w ? '0 : fld[F_SEC] + 12'd1;
      if (s_w) begin
        nxt[F_MIN] = m_w ? '0 : fld[F_MIN] + 12'd1;
        if (m_w) begin
          nxt[F_HOUR] = h_w ? '0 : fld[F_HOUR] + 12'd1;
          if (h_w) begin
            nxt[F_DOW] = (fld[F_DOW] >= 12'd6) ? '0 : fld[F_DOW] + 12'd1;
            nxt[F_DOM] = d_w ? 12'd1 : fld[F_DOM] + 12'd1;
            nxt[F_DOY] = (d_w && mo_w) ? 12'd1 : fld[F_DOY] + 12'd1;
            if (d_w) begin
              nxt[F_MON] = mo_w ? 12'd1 : fld[F_MON] + 12'd1;
              if (mo_w) nxt[F_YEAR] = fld[F_YEAR] + 12'd1;
            end
          end
        end
      end
    end
    if (wr_en) nxt[wr_idx] = wr_val & fld_mask(int'(wr_idx));
    for (int i = 0; i < NFLD; i++) changed[i] = adv && (nxt[i] != fld[i]);
    upd = adv || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld         <= '0;
      fld[F_DOM]  <= 12'd1;
      fld[F_DOY]  <= 12'd1;
      fld[F_MON]  <= 12'd1;
    end else if (upd) begin
      fld <= nxt;
    end
  end

  // R3: seconds wrap to zero after 59
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && fld[F_SEC] >= 12'd59) |=> fld[F_SEC] == 12'd0);
  // R3: seconds step by one below 59
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && fld[F_SEC] < 12'd59) |=> fld[F_SEC] == $past(fld[F_SEC]) + 12'd1);
  // R4: end of month returns day of month to 1
  a_r4_dom_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && s_w && m_w && h_w && d_w) |=> fld[F_DOM] == 12'd1);
  // R6: a written value is what the field holds next
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fld[$past(wr_idx)] == ($past(wr_val) & fld_mask(int'($past(wr_idx)))));
endmodule

// File: rtl/rtc_events.sv
module rtc_events
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [NFLD-1:0] changed,
  input  fields_t         fld,
  input  fields_t         alm,
  input  logic [NFLD-1:0] mask,
  input  logic            pend_wr,
  input  logic            flag_wr,
  input  logic [NFLD-1:0] wdata,
  output logic [NFLD-1:0] pend,
  output logic [1:0]      flags,
  output logic            irq
);
  logic            cmp_q, match, pend_en, flag_en;
  logic [NFLD-1:0] hit, pend_d;
  logic [1:0]      flags_d;

  always_comb begin
    for (int i = 0; i < NFLD; i++) hit[i] = mask[i] || (fld[i] == alm[i]);
    match   = cmp_q && (&hit) && (mask != {NFLD{1'b1}});
    pend_d  = (pend_wr ? wdata : pend) | changed;
    pend_en = pend_wr || (|changed);
    flags_d = (flags & ~(flag_wr ? wdata[1:0] : 2'b00)) | {match, adv};
    flag_en = flag_wr || match || adv;
    irq     = (|pend) || flags[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      pend  <= '0;
      flags <= '0;
    end else begin
      cmp_q <= adv;
      if (pend_en) pend  <= pend_d;
      if (flag_en) flags <= flags_d;
    end
  end

  // R9: the alarm flag rises only in the clock after a tick
  a_r9_alarm_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(cmp_q));
  // R10: a full mask never lets the alarm fire
  a_r10_full_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(mask) != {NFLD{1'b1}});
  // R11: writing zero empties the pending word when nothing advances
  a_r11_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && wdata == '0 && !adv) |=> pend == '0);
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_CYCLES = 32768,
  parameter int CAL_W      = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [1:0]      rs_q;
  logic            rst_i;
  logic            run_q, hold_q, caloff_q;
  logic [NFLD-1:0] mask_q;
  fields_t         alm_q, fld;
  logic [CAL_W:0]  cal_q;
  logic            we, cnt_wr, alm_wr, tick, adv;
  logic [NFLD-1:0] changed, pend;
  logic [1:0]      flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    we     = bus_sel && bus_wr;
    cnt_wr = we && (bus_addr[7:5] == REGION_FLD);
    alm_wr = we && (bus_addr[7:5] == REGION_ALM);
    adv    = tick && !cnt_wr;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q    <= 1'b0;
      hold_q   <= 1'b0;
      caloff_q <= 1'b0;
      mask_q   <= '1;
      alm_q    <= '0;
      cal_q    <= '0;
    end else begin
      if (we && bus_addr == A_CTRL) begin
        run_q    <= bus_wdata[0];
        hold_q   <= bus_wdata[1];
        caloff_q <= bus_wdata[4];
      end
      if (we && bus_addr == A_MASK) mask_q <= bus_wdata[NFLD-1:0];
      if (we && bus_addr == A_CAL)  cal_q  <= bus_wdata[CAL_W:0];
      if (alm_wr) alm_q[bus_addr[4:2]] <= bus_wdata[FLD_W-1:0] & fld_mask(int'(bus_addr[4:2]));
    end
  end

  rtc_divider #(.DIV(DIV_CYCLES), .CAL_W(CAL_W)) u_div (
    .clk(clk), .rst_n(rst_i), .run(run_q), .hold(hold_q), .cal_en(!caloff_q),
    .cal_back(cal_q[CAL_W]), .cal_cnt(cal_q[CAL_W-1:0]), .tick(tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_i), .adv(adv), .wr_en(cnt_wr), .wr_idx(bus_addr[4:2]),
    .wr_val(bus_wdata[FLD_W-1:0]), .fld(fld), .changed(changed)
  );

  rtc_events u_evt (
    .clk(clk), .rst_n(rst_i), .adv(adv), .changed(changed), .fld(fld), .alm(alm_q),
    .mask(mask_q), .pend_wr(we && bus_addr == A_PEND), .flag_wr(we && bus_addr == A_FLAG),
    .wdata(bus_wdata[NFLD-1:0]), .pend(pend), .flags(flags), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == REGION_FLD) begin
      bus_rdata[FLD_W-1:0] = fld[bus_addr[4:2]];
    end else if (bus_addr[7:5] == REGION_ALM) begin
      bus_rdata[FLD_W-1:0] = alm_q[bus_addr[4:2]];
    end else begin
      case (bus_addr)
        A_FLAG: bus_rdata[1:0] = flags;
        A_CTRL: begin
          bus_rdata[0] = run_q;
          bus_rdata[1] = hold_q;
          bus_rdata[4] = caloff_q;
        end
        A_PEND: bus_rdata[NFLD-1:0] = pend;
        A_MASK: bus_rdata[NFLD-1:0] = mask_q;
        A_PK0:  bus_rdata = {5'd0, fld[F_DOW][2:0], 3'd0, fld[F_HOUR][4:0],
                             2'd0, fld[F_MIN][5:0], 2'd0, fld[F_SEC][5:0]};
        A_PK1:  bus_rdata = {4'd0, fld[F_YEAR], 4'd0, fld[F_MON][3:0], 3'd0, fld[F_DOM][4:0]};
        A_PK2:  bus_rdata = {20'd0, fld[F_DOY]};
        A_CAL:  bus_rdata[CAL_W:0] = cal_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/cal_rtc_bench.sv
module cal_rtc_bench;
  localparam int DIV = 8;
  localparam logic [7:0] FLAG = 8'h00, CTRL = 8'h08, PEND = 8'h0C, MASK = 8'h10;
  localparam logic [7:0] PK0 = 8'h14, PK1 = 8'h18, PK2 = 8'h1C, CAL = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  int          md[8];

  always #4 clk = ~clk;

  cal_rtc #(.DIV_CYCLES(DIV)) u_cal_rtc (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    bit nd, nm;
    md[0]++;
    if (md[0] < 60) return;
    md[0] = 0; md[1]++;
    if (md[1] < 60) return;
    md[1] = 0; md[2]++;
    if (md[2] < 24) return;
    md[2] = 0;
    md[4] = (md[4] + 1) % 7;
    nd = (md[3] >= mdays(md[6], md[7]));
    nm = nd && (md[6] >= 12);
    md[3] = nd ? 1 : md[3] + 1;
    md[5] = nm ? 1 : md[5] + 1;
    if (nd) md[6] = nm ? 1 : md[6] + 1;
    if (nm) md[7] = (md[7] + 1) % 4096;
  endtask

  task automatic load_fields();
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(4 * i), 32'(md[i]));
  endtask

  task automatic run_ticks(input int k, input logic [31:0] ctl);
    wr(CTRL, ctl);
    repeat (k * DIV) @(negedge clk);
    wr(CTRL, 32'h2);
  endtask

  task automatic cmp_fields(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(4 * i), d);
      chk(tag, d, 32'(md[i]));
    end
    rd(PK0, d); chk("R7 pk0", d, 32'(md[0] | (md[1] << 8) | (md[2] << 16) | (md[4] << 24)));
    rd(PK1, d); chk("R7 pk1", d, 32'(md[3] | (md[6] << 8) | (md[7] << 16)));
    rd(PK2, d); chk("R7 pk2", d, 32'(md[5]));
  endtask

  task automatic set_md(input int s, input int mi, input int h, input int dm,
                        input int dw, input int dy, input int mo, input int y);
    md[0] = s; md[1] = mi; md[2] = h; md[3] = dm; md[4] = dw; md[5] = dy; md[6] = mo; md[7] = y;
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    int k, dm;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    set_md(0, 0, 0, 1, 0, 1, 1, 0);
    cmp_fields("R1 field");
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(PEND, d); chk("R1 pend", d, 0);
    rd(FLAG, d); chk("R1 flag", d, 0);
    rd(CAL, d);  chk("R1 cal", d, 0);
    rd(MASK, d); chk("R1 mask", d, 32'hFF);
    chk("R1 irq", 32'(irq), 0);

    // R5 write truncation to field width
    wr(CTRL, 32'h2);
    wr(8'h30, 32'hFF);
    rd(8'h30, d); chk("R5 dow width", d, 32'h7);

    // R2 plain counting, hold and stop
    set_md(0, 0, 0, 1, 0, 1, 1, 0); load_fields();
    run_ticks(3, 32'h1);
    rd(8'h20, d); chk("R2 three ticks", d, 3);
    run_ticks(3, 32'h3);
    rd(8'h20, d); chk("R2 hold no tick", d, 3);
    run_ticks(3, 32'h0);
    rd(8'h20, d); chk("R2 stopped no tick", d, 3);

    // R3 R4 R5 R7 random starts near boundaries
    for (int it = 0; it < 40; it++) begin
      md[7] = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 4095)) : int'($urandom_range(2020, 2030));
      md[6] = $urandom_range(1, 12);
      dm    = mdays(md[6], md[7]);
      md[3] = ($urandom_range(0, 1) == 1) ? dm : int'($urandom_range(1, dm));
      md[2] = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
      md[1] = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      md[0] = ($urandom_range(0, 3) != 0) ? int'($urandom_range(56, 59)) : int'($urandom_range(0, 59));
      md[4] = $urandom_range(0, 6);
      md[5] = $urandom_range(1, 366);
      k     = $urandom_range(1, 4);
      wr(CTRL, 32'h2);
      load_fields();
      run_ticks(k, 32'h1);
      for (int t = 0; t < k; t++) model_tick();
      cmp_fields("R3/R4/R5 random");
    end

    // R4 leap and non-leap February, year wrap; R11 all fields change
    set_md(59, 59, 23, 28, 3, 59, 2, 2024); wr(CTRL, 32'h2); load_fields();
    run_ticks(1, 32'h1); model_tick(); cmp_fields("R4 leap feb");
    set_md(59, 59, 23, 28, 3, 59, 2, 2023); wr(CTRL, 32'h2); load_fields();
    run_ticks(1, 32'h1); model_tick(); cmp_fields("R4 plain feb");
    set_md(59, 59, 23, 31, 6, 365, 12, 4095); wr(CTRL, 32'h2); load_fields();
    wr(PEND, 0); wr(FLAG, 32'h3);
    run_ticks(1, 32'h1); model_tick(); cmp_fields("R4 year wrap");
    rd(PEND, d); chk("R11 all fields pend", d, 32'hFF);
    rd(FLAG, d); chk("R11 tick flag", d & 1, 1);

    // R11 seconds only, write replaces, zero clears; R12
    set_md(10, 5, 5, 5, 1, 5, 1, 2000); load_fields();
    wr(PEND, 0);
    run_ticks(1, 32'h1);
    rd(PEND, d); chk("R11 sec pend", d, 32'h01);
    chk("R12 irq pend", 32'(irq), 1);
    wr(PEND, 32'h5A); rd(PEND, d); chk("R11 replace", d, 32'h5A);
    wr(PEND, 0); rd(PEND, d); chk("R11 clear", d, 0);
    wr(FLAG, 32'h1); rd(FLAG, d); chk("R12 w1c flag0", d, 0);
    chk("R12 irq idle", 32'(irq), 0);

    // R6 write coinciding with a tick
    set_md(59, 7, 5, 5, 1, 5, 1, 2000); wr(CTRL, 32'h2); load_fields();
    wr(CTRL, 32'h1);
    repeat (DIV - 2) @(negedge clk);
    wr(8'h20, 32'd30);
    wr(CTRL, 32'h2);
    rd(8'h20, d); chk("R6 sec kept", d, 30);
    rd(8'h24, d); chk("R6 no carry", d, 7);

    // R8 calibration
    wr(8'h20, 0); wr(CAL, 32'h3);
    rd(CAL, d); chk("R8 cal readback", d, 3);
    run_ticks(6, 32'h1);
    rd(8'h20, d); chk("R8 forward", d, 8);
    wr(8'h20, 0); wr(CAL, 32'h20003);
    run_ticks(6, 32'h1);
    rd(8'h20, d); chk("R8 backward", d, 4);
    wr(8'h20, 0);
    run_ticks(6, 32'h11);
    rd(8'h20, d); chk("R8 disabled", d, 6);
    wr(CAL, 0);

    // R9 R10 R12 alarm
    set_md(3, 7, 0, 1, 0, 1, 1, 0); wr(CTRL, 32'h2); load_fields();
    wr(8'h60, 5); wr(8'h64, 9);
    wr(MASK, 32'hFE); wr(FLAG, 32'h3); wr(PEND, 0);
    run_ticks(2, 32'h1);
    rd(FLAG, d); chk("R9 sec match", d & 2, 2);
    @(negedge clk); chk("R12 irq alarm", 32'(irq), 1);
    wr(FLAG, 32'h2); rd(FLAG, d); chk("R12 w1c alarm", d & 2, 0);
    wr(PEND, 0); @(negedge clk); chk("R12 irq cleared", 32'(irq), 0);
    repeat (3 * DIV) @(negedge clk);
    rd(FLAG, d); chk("R10 no refire without tick", d & 2, 0);
    wr(8'h20, 3); wr(MASK, 32'hFC);
    run_ticks(2, 32'h1);
    rd(FLAG, d); chk("R9 minute mismatch", d & 2, 0);
    wr(8'h20, 3); wr(MASK, 32'hFF);
    run_ticks(2, 32'h1);
    rd(FLAG, d); chk("R10 full mask", d & 2, 0);
    wr(8'h20, 3);
    wr(8'h64, 7); wr(8'h6C, 1); wr(8'h74, 1); wr(8'h78, 1);
    wr(MASK, 32'h00);
    run_ticks(2, 32'h1);
    rd(FLAG, d); chk("R9 all fields", d & 2, 2);
    rd(8'h6C, d); chk("R9 alarm readback", d, 1);

    finish_up();
  end
endmodule